// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

This is a purely combinational shifter for the execution stage of a 64-bit processor. It takes a 64-bit operand and produces a 64-bit result. The result is the operand shifted left, shifted right logically, shifted right arithmetically, or rotated right. There is no clock or state inside the block. The result follows the inputs in the same evaluation step, so the surrounding pipeline owns all registering.

Every operation comes in three forms, each with its own source for the shift amount:

- an immediate amount of 0 to 31, used as given;
- the same 5-bit immediate with 32 added, covering 32 to 63;
- a variable amount taken from the low six bits of a register operand.

A 4-bit select chooses both the kind and the form. The select code with no defined form drives a zero result.

Internally the unit has three stages. It first reduces every form to a single 6-bit amount. A logarithmic right rotator then moves the data. A merge stage masks in fill bits, which are zeros or copies of the sign bit. Left shifts reuse the same right-going path by reversing the bit order before and after it.

Top module: `shift_rotate_unit`

## Requirements
- R1: `op_sel[1:0]` picks the kind (0 = shift left, 1 = logical shift right, 2 = arithmetic shift right, 3 = rotate right) and `op_sel[3:2]` picks the form (0 = immediate, 1 = immediate plus 32, 2 = variable); all-zero inputs give a zero result.
- R2: In the immediate form the amount is `imm_amt` (0 to 31).
- R3: In the immediate-plus-32 form the amount is `imm_amt + 32` (32 to 63).
- R4: In the variable form the amount is `amt_reg[5:0]`; bits 63:6 of `amt_reg` have no effect on the result.
- R5: A left shift by n moves bit i to bit i+n and fills bits n-1:0 with zeros.
- R6: A logical right shift by n moves bit i to bit i-n and fills the top n bits with zeros.
- R7: An arithmetic right shift by n fills the top n bits with copies of `operand[63]`.
- R8: A rotate right by n places bit i at bit (i-n) mod 64, losing no bit.
- R9: A rotate whose effective amount is zero returns the operand unchanged, in both the immediate and the variable forms.
- R10: Form code 3 (`op_sel[3:2]` = 3) drives a result of zero for every kind and operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 64 | Data to be shifted or rotated |
| imm_amt | input | 5 | Immediate shift amount |
| amt_reg | input | 64 | Register holding the variable shift amount (low 6 bits used) |
| op_sel | input | 4 | Kind in bits 1:0, form in bits 3:2 |
| result | output | 64 | Shifted or rotated data |

## Verification
The bound checker watches several properties on every input change:

- the sign bit is preserved by an arithmetic right shift;
- a nonzero logical right shift clears the top bit, and a nonzero left shift clears the bottom bit;
- a rotate keeps the population count;
- a zero-amount rotate passes the operand through;
- form code 3 gives zero.

Exact bit placement, and the way each form turns its amount into an effective shift, can only be shown by the bench. The bench compares every kind and form against a reference model over all reachable amounts. It uses random and edge operands, and it puts random data in the ignored upper bits of the amount register.

// File: rtl/sru_pkg.sv
// Shared encodings for the shift and rotate unit.
// Assumes the select is a 4-bit field with the kind in its low two bits.
package sru_pkg;
    typedef enum logic [1:0] {
        KIND_SLL = 2'd0,
        KIND_SRL = 2'd1,
        KIND_SRA = 2'd2,
        KIND_ROR = 2'd3
    } sru_kind_e;

    typedef enum logic [1:0] {
        FORM_IMM    = 2'd0,
        FORM_IMM_HI = 2'd1,
        FORM_VAR    = 2'd2,
        FORM_NONE   = 2'd3
    } sru_form_e;

    typedef struct packed {
        sru_form_e form;
        sru_kind_e kind;
    } sru_op_t;
endpackage

// File: rtl/sru_amount_dec.sv
// Reduces the three amount forms to one effective amount.
// Assumes IMM_W < AMT_W, so that adding half the width never wraps.
module sru_amount_dec
    import sru_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  sru_form_e          form_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [DATA_W-1:0]  amt_reg_i,
    output logic [AMT_W-1:0]   amt_o,
    output logic               valid_o
);
    localparam logic [AMT_W-1:0] HALF = AMT_W'(DATA_W / 2);

    // Select the amount source by form; the truncating cast keeps only the low register bits.
    always_comb begin
        valid_o = 1'b1;
        unique case (form_i)
            FORM_IMM:    amt_o = AMT_W'(imm_i);
            FORM_IMM_HI: amt_o = AMT_W'(imm_i) + HALF;
            FORM_VAR:    amt_o = AMT_W'(amt_reg_i);
            default: begin
                amt_o   = '0;
                valid_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sru_rotator.sv
// Logarithmic right rotator: one stage per amount bit, stage s rotates by 2**s.
// Assumes DATA_W is a power of two.
module sru_rotator #(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] data_o
);
    logic [AMT_W:0][DATA_W-1:0] stage;

    assign stage[0] = data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        // Rotate right by SH when this amount bit is set.
        assign stage[s+1] = amt_i[s] ? {stage[s][SH-1:0], stage[s][DATA_W-1:SH]}
                                     : stage[s];
    end

    assign data_o = stage[AMT_W];
endmodule

// File: rtl/sru_fill_merge.sv
// Turns a rotated word into a right shift by replacing the wrapped bits with fill.
// Assumes the rotated word came from the same amount; wrap_i keeps rotation intact.
module sru_fill_merge #(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rot_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              sign_i,
    input  logic              arith_i,
    input  logic              wrap_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] fill;

    // Build a mask of surviving low bits and the fill pattern for the vacated top.
    always_comb begin
        keep = {DATA_W{1'b1}} >> amt_i;
        fill = {DATA_W{arith_i & sign_i}};
    end

    // Merge rotated data with fill unless a plain rotation is wanted.
    always_comb begin
        if (wrap_i) data_o = rot_i;
        else        data_o = (rot_i & keep) | (fill & ~keep);
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Combinational 64-bit shifter with left, logical right, arithmetic right and rotate right.
// Left shifts reuse the right path through bit reversal. Assumes DATA_W is a power of two.
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [IMM_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [3:0]        op_sel,
    output logic [DATA_W-1:0] result
);
    sru_op_t            op_s;
    logic [AMT_W-1:0]   amt;
    logic               valid;
    logic               is_left;
    logic [DATA_W-1:0]  rev_in;
    logic [DATA_W-1:0]  src;
    logic [DATA_W-1:0]  rot;
    logic [DATA_W-1:0]  merged;
    logic [DATA_W-1:0]  rev_out;

    assign op_s    = sru_op_t'(op_sel);
    assign is_left = (op_s.kind == KIND_SLL);

    sru_amount_dec #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dec (
        .form_i    (op_s.form),
        .imm_i     (imm_amt),
        .amt_reg_i (amt_reg),
        .amt_o     (amt),
        .valid_o   (valid)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]  = operand[DATA_W-1-i];
        assign rev_out[i] = merged[DATA_W-1-i];
    end

    // Feed the right path with the reversed operand for left shifts.
    assign src = is_left ? rev_in : operand;

    sru_rotator #(.DATA_W(DATA_W)) u_rot (
        .data_i (src),
        .amt_i  (amt),
        .data_o (rot)
    );

    sru_fill_merge #(.DATA_W(DATA_W)) u_merge (
        .rot_i   (rot),
        .amt_i   (amt),
        .sign_i  (operand[DATA_W-1]),
        .arith_i (op_s.kind == KIND_SRA),
        .wrap_i  (op_s.kind == KIND_ROR),
        .data_o  (merged)
    );

    // Undo the reversal for left shifts and force zero for the undefined form.
    always_comb begin
        if (!valid)       result = '0;
        else if (is_left) result = rev_out;
        else              result = merged;
    end
endmodule

// File: rtl/sru_checker.sv
// Port-level property checker for shift_rotate_unit, attached by bind.
// Assumes the unit is combinational, so checks are evaluated on every input change.
module sru_checker
    import sru_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] operand,
    input logic [IMM_W-1:0]  imm_amt,
    input logic [DATA_W-1:0] amt_reg,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] result
);
    sru_op_t          op_s;
    logic [AMT_W-1:0] eff;

    assign op_s = sru_op_t'(op_sel);

    // Independent view of the effective amount, for conditioning the checks.
    always_comb begin
        case (op_s.form)
            FORM_IMM:    eff = AMT_W'(imm_amt);
            FORM_IMM_HI: eff = AMT_W'(imm_amt) + AMT_W'(DATA_W / 2);
            default:     eff = AMT_W'(amt_reg);
        endcase
    end

    // Check the port relationships each time the inputs settle.
    always_comb begin
        if (op_s.form == FORM_NONE) begin
            a_r10_unused_zero: assert (result == '0)
                else $error("R10 undefined form gave nonzero result");
        end else begin
            if (op_s.kind == KIND_SRA) begin
                a_r7_sign_kept: assert (result[DATA_W-1] == operand[DATA_W-1])
                    else $error("R7 sign bit not preserved");
            end
            if (op_s.kind == KIND_SRL && eff != '0) begin
                a_r6_top_zero: assert (result[DATA_W-1] == 1'b0)
                    else $error("R6 top bit not cleared");
            end
            if (op_s.kind == KIND_SLL && eff != '0) begin
                a_r5_low_zero: assert (result[0] == 1'b0)
                    else $error("R5 low bit not cleared");
            end
            if (op_s.kind == KIND_ROR) begin
                a_r8_bits_kept: assert ($countones(result) == $countones(operand))
                    else $error("R8 rotate changed population count");
            end
            if (op_s.kind == KIND_ROR && eff == '0) begin
                a_r9_rot_zero_pass: assert (result == operand)
                    else $error("R9 zero rotate altered operand");
            end
        end
    end
endmodule

bind shift_rotate_unit sru_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sru_checker (
    .operand (operand),
    .imm_amt (imm_amt),
    .amt_reg (amt_reg),
    .op_sel  (op_sel),
    .result  (result)
);

// File: tb/test_shift_rotate_unit.sv
// Scoreboard bench: the driver applies stimulus on the rising edge and queues the
// expected result; the monitor pops and compares on the falling edge.
module test_shift_rotate_unit;
    localparam int DATA_W = 64;
    localparam int IMM_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] operand = '0;
    logic [IMM_W-1:0]  imm_amt = '0;
    logic [DATA_W-1:0] amt_reg = '0;
    logic [3:0]        op_sel  = '0;
    logic [DATA_W-1:0] result;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    always #5 clk = ~clk;

    shift_rotate_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_shift_rotate_unit (
        .operand (operand),
        .imm_amt (imm_amt),
        .amt_reg (amt_reg),
        .op_sel  (op_sel),
        .result  (result)
    );

    // Reference model written from the requirement list.
    function automatic logic [DATA_W-1:0] model(input int kind, input int n,
                                                input logic [DATA_W-1:0] x);
        case (kind)
            0: return x << n;
            1: return x >> n;
            2: return DATA_W'($signed(x) >>> n);
            default: return (n == 0) ? x : ((x >> n) | (x << (DATA_W - n)));
        endcase
    endfunction

    function automatic string kind_tag(input int kind);
        case (kind)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic string form_tag(input int form);
        case (form)
            0: return "R2";
            1: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Drive one operation and queue its expected result.
    task automatic drive(input int kind, input int form, input logic [IMM_W-1:0] imm_v,
                         input logic [DATA_W-1:0] areg, input logic [DATA_W-1:0] x,
                         input string tag_in);
        item_t it;
        int    n;
        @(posedge clk);
        operand = x;
        imm_amt = imm_v;
        amt_reg = areg;
        op_sel  = {2'(form), 2'(kind)};
        case (form)
            0: n = int'(imm_v);
            1: n = int'(imm_v) + 32;
            default: n = int'(areg[5:0]);
        endcase
        it.exp = (form == 3) ? '0 : model(kind, n, x);
        if (tag_in != "")                  it.tag = tag_in;
        else if (kind == 3 && n == 0)      it.tag = "R9";
        else                               it.tag = {kind_tag(kind), "/", form_tag(form)};
        sbq.push_back(it);
    endtask

    // Monitor: compare the settled output with the queued expectation.
    always @(negedge clk) begin
        item_t got;
        if (sbq.size() > 0) begin
            got = sbq.pop_front();
            checks++;
            if (result !== got.exp) begin
                fails++;
                $display("FAIL %s: op=%h actual=%h expected=%h", got.tag, op_sel, result, got.exp);
            end
        end
    end

    function automatic logic [DATA_W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-time state: all-zero inputs give zero (R1).
        drive(0, 0, 5'd0, '0, '0, "R1");
        // Encoding: kind 0 form 0 shifts left by the immediate (R1).
        drive(0, 0, 5'd1, '0, 64'h1, "R1");
        drive(3, 0, 5'd4, '0, 64'hF, "R1");

        for (int pat = 0; pat < 3; pat++) begin
            for (int kind = 0; kind < 4; kind++) begin
                for (int a = 0; a < 32; a++) begin
                    logic [DATA_W-1:0] x;
                    x = (pat == 0) ? rnd64() : (pat == 1) ? {1'b1, 63'(rnd64())} : 64'hFFFF_FFFF_FFFF_FFFF;
                    drive(kind, 0, 5'(a), rnd64(), x, "");
                    drive(kind, 1, 5'(a), rnd64(), x, "");
                end
                for (int a = 0; a < 64; a++) begin
                    logic [DATA_W-1:0] x;
                    x = (pat == 0) ? rnd64() : (pat == 1) ? {1'b1, 63'(rnd64())} : 64'h8000_0000_0000_0001;
                    // Random data in bits 63:6 of the amount register must be ignored (R4).
                    drive(kind, 2, rnd64()[4:0], {rnd64()[63:6], 6'(a)}, x, "");
                end
            end
        end

        // Zero rotate in both forms returns the operand (R9).
        drive(3, 0, 5'd0, rnd64(), 64'hDEAD_BEEF_0123_4567, "R9");
        drive(3, 2, 5'd7, 64'hFFFF_FFFF_FFFF_FFC0, 64'h8000_0000_0000_0001, "R9");
        // Upper amount bits alone must not shift (R4).
        drive(1, 2, 5'd0, 64'hFFFF_FFFF_FFFF_FFC0, 64'h8000_0000_0000_0000, "R4");
        // Undefined form code gives zero for every kind (R10).
        for (int kind = 0; kind < 4; kind++)
            drive(kind, 3, 5'd9, rnd64(), 64'hFFFF_FFFF_FFFF_FFFF, "R10");

        @(posedge clk);
        while (sbq.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule